// File: doc/BRIEF.md
# Tri-State Phase-Frequency Comparator

This block is the digital phase-frequency comparator of one synthesizer loop. It watches two pulse trains that are already synchronous to the oscillator clock: the divided reference and the divided VCO feedback. It keeps one correction flag per input. The first rising edge sets its own flag, and the later edge sets the other one. One cycle after both flags are set, the two flags clear together. Extra edges from the leading input before the lagging edge arrives are absorbed. Because of this the comparator also pulls the loop in frequency, over the full minus to plus two pi range.

Each flag feeds a correction channel. A channel stays active for at least `MIN_PW` oscillator cycles, so an exact phase match still produces short pulses and the loop has no dead zone. A polarity input decides which channel raises the charge-pump pin and which lowers it, so VCOs with either tuning slope can be used. The pin is exported as drive-high and drive-low bits plus an enable and a level for a single three-state pad. When both channels overlap, the pad follows the input that led. An exact tie counts as the reference leading.

For a separate lock detector, the block reports the width of each phase-error window in oscillator cycles, together with which input led. This report comes once per comparison.

Top module: `phase_freq_comparator`

## Requirements
- R1: While `rst_n` is low at a clock edge, all correction state clears. After that edge, `drv_hi`, `drv_lo`, `pin_oe`, `pin_lvl` and `err_valid` are 0, which leaves the modelled pad high-impedance.
- R2: Let a reference edge be sampled at edge e0 and the VCO edge be sampled d cycles later (d ≥ 1). The reference channel is then active for max(d+1, MIN_PW) cycles, starting in the cycle after e0.
- R3: Every activation of a channel lasts at least MIN_PW cycles (default 2). With zero phase error, both channels are active for exactly MIN_PW cycles.
- R4: The two flags clear together one cycle after both are set. The lagging channel is therefore active from the cycle after its own edge, for exactly MIN_PW cycles. This is the same whether the reference or the VCO leads.
- R5: With `polarity` = 1, the reference channel drives `drv_hi` and the VCO channel drives `drv_lo`. With `polarity` = 0, the two are swapped.
- R6: `pin_oe` is 1 whenever either channel is active. The pad direction follows the lone active channel. When both channels are active, it follows the leading input, and a tie counts as the reference leading. `pin_lvl` is 1 when the followed channel maps to high.
- R7: In the single cycle after the lagging edge is sampled, `err_valid` is 1. In that cycle, `err_cycles` holds d and `err_ref_lead` is 1 when the reference led or tied. In every other cycle, `err_valid` is 0.
- R8: Further rising edges of the leading input before the lagging edge is sampled have no effect. They do not restart the flag, stretch the pulse or change the measured width.
- R9: `err_cycles` saturates at 2^ERR_W−1 when the phase error is longer than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | Divided reference pulse, synchronous to clk |
| vco_pulse | input | 1 | Divided VCO pulse, synchronous to clk |
| polarity | input | 1 | 1: reference lead drives high; 0: reference lead drives low |
| drv_hi | output | 1 | Charge-pump raise control |
| drv_lo | output | 1 | Charge-pump lower control |
| pin_oe | output | 1 | Three-state pad output enable |
| pin_lvl | output | 1 | Three-state pad level when enabled |
| err_valid | output | 1 | One-cycle strobe marking a finished comparison |
| err_cycles | output | ERR_W | Phase-error window in oscillator cycles |
| err_ref_lead | output | 1 | Reference led (or tied) in the reported comparison |

## Verification
An input edge applied before edge e_s is seen by the design at e_s. All channel, pad and error outputs for relative cycle k are valid in the cycle that follows e_k: there is one register stage, and the outputs are decoded from it combinationally. The bench drives the inputs just after a falling edge and samples a quarter period after each rising edge. It predicts the outputs of every cycle of a comparison from d, the leading input and the polarity alone. The error report is checked only in cycle k = d and must be absent in all other cycles. The channel tails are checked up to two cycles beyond MIN_PW.

// File: rtl/phase_cmp_pkg.sv
// Shared constants and helpers for the phase-frequency comparator.
// Assumes exactly two compared inputs: channel 0 is the reference,
// channel 1 is the VCO feedback.
package phase_cmp_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_REF = 0;
    localparam int CH_VCO = 1;

    typedef logic [NUM_CH-1:0] chvec_t;

    // Pad level for the followed channel: high when that channel maps to raise.
    function automatic logic pad_level(input logic follow_ref, input logic pol);
        return (follow_ref == pol);
    endfunction
endpackage

// File: rtl/pfd_edge_catch.sv
// Rising-edge detector for each compared input.
// Assumes the inputs are already synchronous to clk. A rise is reported
// in the cycle in which the input is first seen high.
module pfd_edge_catch
    import phase_cmp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  chvec_t level_in,
    output chvec_t rise_out
);
    chvec_t prev_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Remember last cycle's level of this input.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= level_in[g];
        end
        assign rise_out[g] = level_in[g] & ~prev_q[g];

        assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rise_out[g] |=> !rise_out[g]);
    end
endmodule

// File: rtl/pfd_flag_ctrl.sv
// Correction-flag state for the comparator.
// An edge sets its own flag. When both flags are set, both clear at the
// next edge, and edges seen in that clearing cycle are dropped. Each
// channel stays active for at least MIN_PW cycles through a hold counter.
// The leading input is latched when a comparison starts from idle; a tie
// counts as the reference leading.
module pfd_flag_ctrl
    import phase_cmp_pkg::*;
#(
    parameter int MIN_PW = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  chvec_t rise_in,
    output chvec_t flag_out,
    output chvec_t act_out,
    output logic   lead_ref
);
    localparam int HW = $clog2(MIN_PW + 1);

    chvec_t          flag_q;
    chvec_t          set_ev;
    logic            clr_both;
    logic            idle;
    logic [HW-1:0]   hold_q [NUM_CH];

    assign clr_both = &flag_q;
    assign idle     = ~|flag_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign set_ev[g] = rise_in[g] & ~flag_q[g] & ~clr_both;

        // Set the flag on its own edge; clear both once both are set.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[g] <= 1'b0;
            else if (clr_both) flag_q[g] <= 1'b0;
            else if (set_ev[g]) flag_q[g] <= 1'b1;
        end

        // Minimum-width hold: load on a fresh set, count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                 hold_q[g] <= '0;
            else if (set_ev[g])         hold_q[g] <= HW'(MIN_PW);
            else if (hold_q[g] != '0)   hold_q[g] <= hold_q[g] - 1'b1;
        end

        assign act_out[g] = flag_q[g] | (hold_q[g] != '0);

        if (MIN_PW >= 2) begin : g_minpw
            assert_min_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(act_out[g]) |=> act_out[g]);
        end

        assert_reset_idle_R1: assert property (@(posedge clk)
            !rst_n |=> (!flag_q[g] && hold_q[g] == '0));
    end

    // Latch which input started the comparison (tie goes to reference).
    always_ff @(posedge clk) begin
        if (!rst_n)                 lead_ref <= 1'b1;
        else if (idle && |set_ev)   lead_ref <= set_ev[CH_REF];
    end

    assign flag_out = flag_q;

    assert_clear_after_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[CH_REF] && flag_q[CH_VCO]) |=> (flag_q == '0));
endmodule

// File: rtl/pfd_err_meter.sv
// Phase-error window measurement.
// Counts the cycles during which exactly one flag is set, saturating at
// 2^ERR_W-1. The count is reported in the cycle in which both flags are set.
// Assumes the flag behaviour of pfd_flag_ctrl.
module pfd_err_meter
    import phase_cmp_pkg::*;
#(
    parameter int ERR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chvec_t           flag_in,
    output logic             err_valid,
    output logic [ERR_W-1:0] err_cycles
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    logic [ERR_W-1:0] cnt_q;
    logic             single;
    logic             both;

    assign single = flag_in[CH_REF] ^ flag_in[CH_VCO];
    assign both   = flag_in[CH_REF] & flag_in[CH_VCO];

    // Count the one-sided window; restart when the comparison closes.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (both)                       cnt_q <= '0;
        else if (single && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign err_valid  = both;
    assign err_cycles = cnt_q;

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);
    assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (single && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/pfd_pin_map.sv
// Maps the reference and VCO channels onto the raise/lower controls and the
// three-state pad, according to the polarity bit. During overlap the pad
// follows the leading input.
module pfd_pin_map
    import phase_cmp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  chvec_t act_in,
    input  logic   lead_ref,
    input  logic   polarity,
    output logic   drv_hi,
    output logic   drv_lo,
    output logic   pin_oe,
    output logic   pin_lvl
);
    logic follow_ref;

    // Pick the channel that owns the pad and decode the drive controls.
    always_comb begin
        follow_ref = (act_in[CH_REF] & act_in[CH_VCO]) ? lead_ref : act_in[CH_REF];
        drv_hi     = polarity ? act_in[CH_REF] : act_in[CH_VCO];
        drv_lo     = polarity ? act_in[CH_VCO] : act_in[CH_REF];
        pin_oe     = |act_in;
        pin_lvl    = pin_oe & pad_level(follow_ref, polarity);
    end

    assert_pad_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_hi && !drv_lo) |-> (pin_oe && pin_lvl));
    assert_pad_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_lo && !drv_hi) |-> (pin_oe && !pin_lvl));
endmodule

// File: rtl/phase_freq_comparator.sv
// Top of the phase-frequency comparator: edge capture, flag control,
// error measurement and pad mapping.
// Assumes ref_pulse and vco_pulse are synchronous to clk.
module phase_freq_comparator
    import phase_cmp_pkg::*;
#(
    parameter int MIN_PW = 2,
    parameter int ERR_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             vco_pulse,
    input  logic             polarity,
    output logic             drv_hi,
    output logic             drv_lo,
    output logic             pin_oe,
    output logic             pin_lvl,
    output logic             err_valid,
    output logic [ERR_W-1:0] err_cycles,
    output logic             err_ref_lead
);
    chvec_t lvl;
    chvec_t rise;
    chvec_t flag;
    chvec_t act;
    logic   lead_ref;

    assign lvl[CH_REF] = ref_pulse;
    assign lvl[CH_VCO] = vco_pulse;

    pfd_edge_catch u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (lvl),
        .rise_out (rise)
    );

    pfd_flag_ctrl #(.MIN_PW(MIN_PW)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_in  (rise),
        .flag_out (flag),
        .act_out  (act),
        .lead_ref (lead_ref)
    );

    pfd_err_meter #(.ERR_W(ERR_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_in    (flag),
        .err_valid  (err_valid),
        .err_cycles (err_cycles)
    );

    pfd_pin_map u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_in   (act),
        .lead_ref (lead_ref),
        .polarity (polarity),
        .drv_hi   (drv_hi),
        .drv_lo   (drv_lo),
        .pin_oe   (pin_oe),
        .pin_lvl  (pin_lvl)
    );

    assign err_ref_lead = lead_ref;

    assert_polarity_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && polarity) |-> (drv_hi && drv_lo));
endmodule

// File: tb/phase_freq_comparator_tb.sv
// Self-checking bench: sweeps polarity, leading input and phase offset, and
// predicts every output cycle arithmetically.
module phase_freq_comparator_tb_top;
    localparam int CLK_P  = 10;
    localparam int MIN_PW = 2;
    localparam int ERR_W  = 6;
    localparam int SAT    = (1 << ERR_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_pulse = 1'b0;
    logic             vco_pulse = 1'b0;
    logic             polarity = 1'b1;
    logic             drv_hi, drv_lo, pin_oe, pin_lvl, err_valid, err_ref_lead;
    logic [ERR_W-1:0] err_cycles;
    wire              pad;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign pad = pin_oe ? pin_lvl : 1'bz;

    phase_freq_comparator #(.MIN_PW(MIN_PW), .ERR_W(ERR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
        .polarity(polarity), .drv_hi(drv_hi), .drv_lo(drv_lo), .pin_oe(pin_oe),
        .pin_lvl(pin_lvl), .err_valid(err_valid), .err_cycles(err_cycles),
        .err_ref_lead(err_ref_lead)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_pad(input string tag, input logic exp_oe, input logic exp_lvl);
        logic exp_pad;
        exp_pad = exp_oe ? exp_lvl : 1'bz;
        checks++;
        if (pad !== exp_pad) begin
            fails++;
            $display("FAIL %s/R6 pad: actual %b expected %b", tag, pad, exp_pad);
        end
    endtask

    // Leader edge at step 0, lagger at step d; optional extra leader edge.
    task automatic run_case(input string tag, input bit pol, input bit vco_leads,
                            input int d, input int extra);
        bit ref_leads;
        ref_leads = !vco_leads;
        polarity  = pol;
        for (int s = 0; s <= d + MIN_PW + 2; s++) begin
            bit lead_on, lag_on, ref_on, vco_on, exp_hi, exp_lo, fol_ref, oe;
            bit lead_edge, lag_edge;
            @(negedge clk);
            lead_edge = (s == 0) || (s == extra);
            lag_edge  = (s == d);
            ref_pulse = ref_leads ? lead_edge : lag_edge;
            vco_pulse = ref_leads ? lag_edge : lead_edge;
            @(posedge clk);
            #(CLK_P/4);
            lead_on = s < ((d + 1 > MIN_PW) ? d + 1 : MIN_PW);
            lag_on  = (s >= d) && (s < d + MIN_PW);
            ref_on  = ref_leads ? lead_on : lag_on;
            vco_on  = ref_leads ? lag_on : lead_on;
            exp_hi  = pol ? ref_on : vco_on;
            exp_lo  = pol ? vco_on : ref_on;
            oe      = ref_on | vco_on;
            fol_ref = ref_leads ? lead_on : !lead_on;
            chk(tag, "drv_hi", drv_hi, exp_hi);
            chk(tag, "drv_lo", drv_lo, exp_lo);
            chk_pad(tag, oe, fol_ref == pol);
            chk({tag, "/R7"}, "err_valid", err_valid, s == d);
            if (s == d) begin
                chk({tag, "/R7"}, "err_cycles", err_cycles, (d > SAT) ? SAT : d);
                chk({tag, "/R7"}, "err_ref_lead", err_ref_lead, ref_leads);
            end
        end
        @(negedge clk);
        ref_pulse = 1'b0;
        vco_pulse = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        // R1: reset state
        chk("R1", "drv_hi", drv_hi, 0);
        chk("R1", "drv_lo", drv_lo, 0);
        chk("R1", "err_valid", err_valid, 0);
        chk_pad("R1", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int p = 1; p >= 0; p--) begin
            for (int v = 0; v <= 1; v++) begin
                for (int d = 0; d <= 6; d++) begin
                    string tag;
                    if (v == 1 && d == 0) continue;
                    if (d == 0)      tag = "R3";
                    else if (v == 1) tag = "R4";
                    else             tag = "R2";
                    if (p == 0) tag = {tag, "/R5"};
                    run_case(tag, p[0], v[0], d, -1);
                end
            end
        end

        // R8: extra leader edges before the lagging edge are ignored.
        run_case("R8", 1'b1, 1'b0, 5, 2);
        run_case("R8", 1'b0, 1'b1, 6, 3);
        // R9: long phase error saturates the window count.
        run_case("R9", 1'b1, 1'b0, 70, -1);

        // R1: reset during an open comparison clears everything.
        @(negedge clk);
        ref_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #(CLK_P/4);
        chk("R1", "drv_hi mid", drv_hi, 0);
        chk("R1", "drv_lo mid", drv_lo, 0);
        chk_pad("R1", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule